// File: doc/BRIEF.md
# Fractional multiply-accumulate-round unit

This block performs one signed fractional multiply-accumulate with rounding. Two 24-bit two's-complement fractions are multiplied. The product is added to or subtracted from a 56-bit accumulator value supplied at the input. The accumulator is made of an 8-bit extension, a 24-bit middle word and a 24-bit low word. The sum is rounded into the middle word by convergent rounding, and the low word is returned as zero. The block also produces a new condition-code byte. The bench recomputes the overflow, limit, zero, negative, extension and unnormalized bits from scratch. The carry and scaling-status bits are copied from the incoming byte unchanged.

A request is a one-cycle `start_i` pulse with all operands valid. A small controller moves through four named states. IDLE waits for start. The IDLE->MULT transition captures the inputs. MULT->ACCUM registers the scaled and signed product. ACCUM->ROUND registers the 57-bit sum and its overflow. ROUND->IDLE registers the rounded result and flags and raises `done_o` for one cycle. No other transitions exist. A start that arrives outside IDLE is dropped. The scaling mode moves the rounding point and the flag comparison points by one bit.

Top module: `fmac_round_unit`

## Requirements
- R1: The product is the signed integer product of `op_a_i` and `op_b_i`, sign-extended to 56 bits and shifted left by one. It is added to `acc_i` when `sub_i`=0 and subtracted when `sub_i`=1. Swapping the two operands does not change the result. Operands 0x123456 and 0x123456 added to 0x00_100000_000000 give 0x00_1296CE_000000.
- R2: With `scale_i`=00, half of bit 24 (that is, 1 at bit 23) is added to the sum, and bits 23:0 of `acc_o` are zero. If bits 23:0 of the unrounded sum were exactly 0x800000, bit 24 of the result is cleared.
- R3: With `scale_i`=01 (scale down), 1 is added at bit 24, bits 24:0 are cleared, and a tie (bits 24:0 equal to 0x1000000) clears bit 25. With `scale_i`=10 (scale up), 1 is added at bit 22, bits 23:0 are cleared, and a tie is bits 22:0 equal to 0x400000. `scale_i`=11 behaves as 00.
- R4: `ccr_o` layout: bit0 C, bit1 V, bit2 Z, bit3 N, bit4 U, bit5 E, bit6 L, bit7 S. N equals bit 55 of `acc_o`. Z is 1 exactly when all 56 bits of `acc_o` are zero.
- R5: V is 1 when the accumulation or the rounding addition overflows a signed 56-bit value. L is `ccr_i` bit6 OR V, so L is never cleared. C and S are copied from `ccr_i`.
- R6: E is 0 only when result bits 55 down to H are all equal. U is 1 when bits H and H-1 are equal. H is 47 for no scaling, 48 for scale down and 46 for scale up.
- R7: If `start_i` is sampled in IDLE at clock edge n, `done_o` is high for exactly one cycle after edge n+3. `acc_o` and `ccr_o` change only at that edge and hold afterwards.
- R8: A `start_i` pulse while an operation is in progress is ignored. It produces no further `done_o` and does not alter the pending result.
- R9: After reset, `done_o`, `acc_o` and `ccr_o` are zero and the controller is in IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| start_i | input | 1 | one-cycle request strobe |
| op_a_i | input | 24 | first signed fractional operand |
| op_b_i | input | 24 | second signed fractional operand |
| acc_i | input | 56 | current accumulator value |
| sub_i | input | 1 | 1 subtracts the product, 0 adds it |
| scale_i | input | 2 | scaling mode: 00 none, 01 down, 10 up, 11 none |
| ccr_i | input | 8 | incoming condition-code byte |
| acc_o | output | 56 | rounded accumulator result |
| ccr_o | output | 8 | updated condition-code byte |
| done_o | output | 1 | result-valid strobe |

## Verification
The bench builds the unit with its default widths: 24-bit operands and 8 extension bits, so 56 bits in all. These are the only values for which the fixed tie patterns, the flag bit positions and the documented test vector have meaning. At these widths the extreme product (-1 times -1) and overflow from a full-scale accumulator are both reachable. So is the exact-half tie at each of the three rounding points, including a tie that rounds to zero and sets Z. A 64-bit reference model in the bench covers a few hundred random operations in all four scaling codes. Start strobes issued while the unit is busy test that such requests are dropped.

// File: rtl/fmac_pkg.sv
package fmac_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_MULT  = 2'd1,
        ST_ACCUM = 2'd2,
        ST_ROUND = 2'd3
    } fmac_state_e;

    typedef enum logic [1:0] {
        SC_NONE = 2'b00,
        SC_DOWN = 2'b01,
        SC_UP   = 2'b10,
        SC_ALT  = 2'b11
    } fmac_scale_e;

    localparam int CCR_W = 8;
    localparam int CCR_C = 0;
    localparam int CCR_V = 1;
    localparam int CCR_Z = 2;
    localparam int CCR_N = 3;
    localparam int CCR_U = 4;
    localparam int CCR_E = 5;
    localparam int CCR_L = 6;
    localparam int CCR_S = 7;

    localparam int N_SCALE = 3;

    function automatic int scale_offset(input int idx);
        if (idx == 1) begin
            return 1;
        end else if (idx == 2) begin
            return -1;
        end
        return 0;
    endfunction

endpackage

// File: rtl/fmac_ctrl.sv
module fmac_ctrl
    import fmac_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    output fmac_state_e state,
    output logic        ld_in,
    output logic        ld_prod,
    output logic        ld_sum,
    output logic        ld_out
);

    fmac_state_e state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        ld_in    = 1'b0;
        ld_prod  = 1'b0;
        ld_sum   = 1'b0;
        ld_out   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    ld_in    = 1'b1;
                    state_nx = ST_MULT;
                end
            end
            ST_MULT: begin
                ld_prod  = 1'b1;
                state_nx = ST_ACCUM;
            end
            ST_ACCUM: begin
                ld_sum   = 1'b1;
                state_nx = ST_ROUND;
            end
            ST_ROUND: begin
                ld_out   = 1'b1;
                state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    p_accept_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start) |=> (state == ST_MULT));

    p_busy_drops_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> (state != ST_MULT));

    p_round_returns_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ROUND) |=> (state == ST_IDLE));

endmodule

// File: rtl/fmac_product.sv
module fmac_product #(
    parameter int OP_W  = 24,
    parameter int ACC_W = 56
) (
    input  logic [OP_W-1:0]  op_a,
    input  logic [OP_W-1:0]  op_b,
    input  logic             sub,
    output logic [ACC_W-1:0] addend
);

    localparam int PROD_W = 2 * OP_W;
    localparam int PAD_W  = ACC_W - PROD_W;

    logic signed [PROD_W-1:0] raw;
    logic        [ACC_W-1:0]  wide;
    logic        [ACC_W-1:0]  frac;

    always_comb begin
        raw    = $signed(op_a) * $signed(op_b);
        wide   = {{PAD_W{raw[PROD_W-1]}}, raw};
        frac   = {wide[ACC_W-2:0], 1'b0};
        addend = sub ? (~frac + {{(ACC_W-1){1'b0}}, 1'b1}) : frac;
    end

endmodule

// File: rtl/fmac_rounder.sv
module fmac_rounder
    import fmac_pkg::*;
#(
    parameter int OP_W  = 24,
    parameter int ACC_W = 56
) (
    input  logic [ACC_W-1:0] sum,
    input  logic [1:0]       scale,
    output logic [ACC_W-1:0] result,
    output logic             rnd_ovf,
    output logic             ext_flag,
    output logic             unnorm_flag
);

    logic [N_SCALE-1:0][ACC_W-1:0] v_res;
    logic [N_SCALE-1:0]            v_ovf;
    logic [N_SCALE-1:0]            v_ext;
    logic [N_SCALE-1:0]            v_unn;

    for (genvar g = 0; g < N_SCALE; g++) begin : g_mode
        localparam int K     = OP_W + scale_offset(g);
        localparam int CLR   = (K > OP_W) ? K : OP_W;
        localparam int HI    = 2 * OP_W - 1 + scale_offset(g);
        localparam int TOP_N = ACC_W - HI;

        logic [ACC_W:0]   half_x;
        logic [ACC_W-1:0] half;
        logic [ACC_W-1:0] low_mask;
        logic [ACC_W-1:0] clr_mask;
        logic [ACC_W:0]   added;
        logic             tie;
        logic [ACC_W-1:0] r;
        logic [TOP_N-1:0] top;

        always_comb begin
            half_x   = {{ACC_W{1'b0}}, 1'b1} << (K - 1);
            half     = half_x[ACC_W-1:0];
            low_mask = ({{(ACC_W-1){1'b0}}, 1'b1} << K) - {{(ACC_W-1){1'b0}}, 1'b1};
            clr_mask = ({{(ACC_W-1){1'b0}}, 1'b1} << CLR) - {{(ACC_W-1){1'b0}}, 1'b1};
            tie      = ((sum & low_mask) == half);
            added    = {sum[ACC_W-1], sum} + half_x;
            r        = added[ACC_W-1:0];
            if (tie) begin
                r[K] = 1'b0;
            end
            r        = r & ~clr_mask;
            top      = r[ACC_W-1:HI];
            v_res[g] = r;
            v_ovf[g] = added[ACC_W] ^ added[ACC_W-1];
            v_ext[g] = !((&top) || !(|top));
            v_unn[g] = (r[HI] == r[HI-1]);
        end
    end

    logic [1:0] sel;

    always_comb begin
        unique case (scale)
            SC_DOWN: sel = 2'd1;
            SC_UP:   sel = 2'd2;
            default: sel = 2'd0;
        endcase
        result      = v_res[sel];
        rnd_ovf     = v_ovf[sel];
        ext_flag    = v_ext[sel];
        unnorm_flag = v_unn[sel];
    end

endmodule

// File: rtl/fmac_round_unit.sv
module fmac_round_unit
    import fmac_pkg::*;
#(
    parameter int OP_W  = 24,
    parameter int EXT_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_i,
    input  logic [OP_W-1:0]            op_a_i,
    input  logic [OP_W-1:0]            op_b_i,
    input  logic [EXT_W+2*OP_W-1:0]    acc_i,
    input  logic                       sub_i,
    input  logic [1:0]                 scale_i,
    input  logic [7:0]                 ccr_i,
    output logic [EXT_W+2*OP_W-1:0]    acc_o,
    output logic [7:0]                 ccr_o,
    output logic                       done_o
);

    localparam int ACC_W = EXT_W + 2 * OP_W;

    fmac_state_e state;
    logic        ld_in;
    logic        ld_prod;
    logic        ld_sum;
    logic        ld_out;

    logic [OP_W-1:0]  a_q;
    logic [OP_W-1:0]  b_q;
    logic [ACC_W-1:0] acc_q;
    logic             sub_q;
    logic [1:0]       scale_q;
    logic [CCR_W-1:0] ccr_q;
    logic [ACC_W-1:0] addend;
    logic [ACC_W-1:0] addend_q;
    logic [ACC_W:0]   sum_x;
    logic [ACC_W-1:0] sum_q;
    logic             acc_ovf_q;
    logic [ACC_W-1:0] rnd_res;
    logic             rnd_ovf;
    logic             ext_flag;
    logic             unn_flag;
    logic             v_new;
    logic [CCR_W-1:0] ccr_new;

    fmac_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start_i),
        .state   (state),
        .ld_in   (ld_in),
        .ld_prod (ld_prod),
        .ld_sum  (ld_sum),
        .ld_out  (ld_out)
    );

    fmac_product #(.OP_W(OP_W), .ACC_W(ACC_W)) u_prod (
        .op_a   (a_q),
        .op_b   (b_q),
        .sub    (sub_q),
        .addend (addend)
    );

    fmac_rounder #(.OP_W(OP_W), .ACC_W(ACC_W)) u_rnd (
        .sum         (sum_q),
        .scale       (scale_q),
        .result      (rnd_res),
        .rnd_ovf     (rnd_ovf),
        .ext_flag    (ext_flag),
        .unnorm_flag (unn_flag)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q     <= '0;
            b_q     <= '0;
            acc_q   <= '0;
            sub_q   <= 1'b0;
            scale_q <= 2'b00;
            ccr_q   <= '0;
        end else if (ld_in) begin
            a_q     <= op_a_i;
            b_q     <= op_b_i;
            acc_q   <= acc_i;
            sub_q   <= sub_i;
            scale_q <= scale_i;
            ccr_q   <= ccr_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addend_q <= '0;
        end else if (ld_prod) begin
            addend_q <= addend;
        end
    end

    assign sum_x = {acc_q[ACC_W-1], acc_q} + {addend_q[ACC_W-1], addend_q};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q     <= '0;
            acc_ovf_q <= 1'b0;
        end else if (ld_sum) begin
            sum_q     <= sum_x[ACC_W-1:0];
            acc_ovf_q <= sum_x[ACC_W] ^ sum_x[ACC_W-1];
        end
    end

    always_comb begin
        v_new          = acc_ovf_q | rnd_ovf;
        ccr_new        = ccr_q;
        ccr_new[CCR_V] = v_new;
        ccr_new[CCR_Z] = (rnd_res == '0);
        ccr_new[CCR_N] = rnd_res[ACC_W-1];
        ccr_new[CCR_U] = unn_flag;
        ccr_new[CCR_E] = ext_flag;
        ccr_new[CCR_L] = ccr_q[CCR_L] | v_new;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_o  <= '0;
            ccr_o  <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= ld_out;
            if (ld_out) begin
                acc_o <= rnd_res;
                ccr_o <= ccr_new;
            end
        end
    end

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_hold_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_ROUND) |=> ($stable(acc_o) && $stable(ccr_o)));

    p_low_word_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (acc_o[OP_W-1:0] == '0));

    p_neg_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (ccr_o[CCR_N] == acc_o[ACC_W-1]));

    p_zero_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (ccr_o[CCR_Z] == (acc_o == '0)));

    p_limit_on_ovf_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && ccr_o[CCR_V]) |-> ccr_o[CCR_L]);

    p_limit_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && ccr_q[CCR_L]) |-> ccr_o[CCR_L]);

    p_carry_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (ccr_o[CCR_C] == ccr_q[CCR_C] && ccr_o[CCR_S] == ccr_q[CCR_S]));

endmodule

// File: tb/sim_fmac_round_unit.sv
module sim_fmac_round_unit;

    typedef struct {
        logic [55:0] acc;
        logic [7:0]  ccr;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [23:0] op_a_i = '0;
    logic [23:0] op_b_i = '0;
    logic [55:0] acc_i = '0;
    logic        sub_i = 1'b0;
    logic [1:0]  scale_i = 2'b00;
    logic [7:0]  ccr_i = '0;
    logic [55:0] acc_o;
    logic [7:0]  ccr_o;
    logic        done_o;

    int   total = 0;
    int   bad = 0;
    exp_t sb[$];

    always #10 clk = ~clk;

    fmac_round_unit u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .op_a_i  (op_a_i),
        .op_b_i  (op_b_i),
        .acc_i   (acc_i),
        .sub_i   (sub_i),
        .scale_i (scale_i),
        .ccr_i   (ccr_i),
        .acc_o   (acc_o),
        .ccr_o   (ccr_o),
        .done_o  (done_o)
    );

    function automatic longint sx56(input logic [55:0] x);
        return longint'($signed(x));
    endfunction

    function automatic void model(input logic [23:0] a, input logic [23:0] b,
                                  input logic [55:0] acc, input logic neg,
                                  input logic [1:0] sc, input logic [7:0] ci,
                                  output logic [55:0] r, output logic [7:0] co);
        longint pr, s, rs, lim, half;
        logic [63:0] sv, rv;
        logic [55:0] s56, mask;
        logic v, tie, alleq;
        int k, hi, clr;
        pr = longint'($signed(a)) * longint'($signed(b)) * 2;
        if (neg) pr = -pr;
        s   = sx56(acc) + pr;
        lim = longint'(1) << 55;
        v   = (s >= lim) || (s < -lim);
        sv  = s;
        s56 = sv[55:0];
        k   = (sc == 2'b01) ? 25 : (sc == 2'b10) ? 23 : 24;
        hi  = (sc == 2'b01) ? 48 : (sc == 2'b10) ? 46 : 47;
        half = longint'(1) << (k - 1);
        mask = (56'd1 << k) - 56'd1;
        tie  = ((s56 & mask) == 56'(half));
        rs   = sx56(s56) + half;
        if (rs >= lim || rs < -lim) v = 1'b1;
        rv = rs;
        r  = rv[55:0];
        if (tie) r[k] = 1'b0;
        clr = (k > 24) ? k : 24;
        r = r & ~((56'd1 << clr) - 56'd1);
        alleq = 1'b1;
        for (int i = hi; i < 55; i++) begin
            if (r[i] != r[55]) alleq = 1'b0;
        end
        co    = ci;
        co[1] = v;
        co[2] = (r == 56'd0);
        co[3] = r[55];
        co[4] = (r[hi] == r[hi-1]);
        co[5] = !alleq;
        co[6] = ci[6] | v;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [23:0] a, input logic [23:0] b, input logic [55:0] acc,
                         input logic neg, input logic [1:0] sc, input logic [7:0] ci,
                         input string req);
        exp_t e;
        model(a, b, acc, neg, sc, ci, e.acc, e.ccr);
        e.req = req;
        sb.push_back(e);
        @(negedge clk);
        op_a_i = a; op_b_i = b; acc_i = acc; sub_i = neg; scale_i = sc; ccr_i = ci;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (!done_o) @(negedge clk);
    endtask

    always @(negedge clk) begin
        if (rst_n && done_o) begin
            if (sb.size() == 0) begin
                total++;
                bad++;
                $display("FAIL R8 unexpected done actual=1 expected=0");
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({e.req, " result"}, {8'h0, acc_o}, {8'h0, e.acc});
                check({e.req, " flags"}, {56'h0, ccr_o}, {56'h0, e.ccr});
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [55:0] er;
        logic [7:0]  ec;
        exp_t        e;
        repeat (3) @(negedge clk);
        check("R9 reset done", {63'h0, done_o}, 64'h0);
        check("R9 reset acc", {8'h0, acc_o}, 64'h0);
        check("R9 reset ccr", {56'h0, ccr_o}, 64'h0);
        rst_n = 1'b1;

        // R1 stated vector, expected result written out
        model(24'h123456, 24'h123456, 56'h00_100000_000000, 1'b0, 2'b00, 8'h00, er, ec);
        e.acc = 56'h00_1296CE_000000; e.ccr = ec; e.req = "R1 vector";
        sb.push_back(e);
        @(negedge clk);
        op_a_i = 24'h123456; op_b_i = 24'h123456; acc_i = 56'h00_100000_000000;
        sub_i = 1'b0; scale_i = 2'b00; ccr_i = 8'h00;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        // R7 latency: start sampled at the edge before this negedge
        check("R7 done low 1", {63'h0, done_o}, 64'h0);
        @(negedge clk);
        check("R7 done low 2", {63'h0, done_o}, 64'h0);
        @(negedge clk);
        check("R7 done low 3", {63'h0, done_o}, 64'h0);
        @(negedge clk);
        check("R7 done high", {63'h0, done_o}, 64'h1);
        @(negedge clk);
        check("R7 done single", {63'h0, done_o}, 64'h0);
        repeat (2) @(negedge clk);
        check("R7 result held", {8'h0, acc_o}, 64'h00_1296CE_000000);

        issue(24'h123456, 24'h123456, 56'h00_100000_000000, 1'b1, 2'b00, 8'h00, "R1 subtract");
        issue(24'h7A0001, 24'hC34567, 56'h01_234567_89ABCD, 1'b0, 2'b00, 8'h00, "R1 order ab");
        issue(24'hC34567, 24'h7A0001, 56'h01_234567_89ABCD, 1'b0, 2'b00, 8'h00, "R1 order ba");
        issue(24'h800000, 24'h800000, 56'h0, 1'b0, 2'b00, 8'h00, "R6 minus one squared");
        issue(24'h0, 24'h0, 56'h00_000000_800000, 1'b0, 2'b00, 8'h00, "R2 tie to zero");
        issue(24'h0, 24'h0, 56'h00_000001_800000, 1'b0, 2'b00, 8'h00, "R2 tie to even");
        issue(24'h0, 24'h0, 56'h00_000000_800001, 1'b0, 2'b00, 8'h00, "R2 above half");
        issue(24'h0, 24'h0, 56'h00_000001_000000, 1'b0, 2'b01, 8'h00, "R3 down tie");
        issue(24'h0, 24'h0, 56'h00_000003_000000, 1'b0, 2'b01, 8'h00, "R3 down tie even");
        issue(24'h0, 24'h0, 56'h00_000000_400000, 1'b0, 2'b10, 8'h00, "R3 up tie");
        issue(24'h0, 24'h0, 56'h00_000000_C00000, 1'b0, 2'b10, 8'h00, "R3 up round");
        issue(24'h123456, 24'h654321, 56'hFF_876543_210FED, 1'b0, 2'b11, 8'h00, "R3 code 11");
        issue(24'h7FFFFF, 24'h7FFFFF, 56'h7F_FFFFFF_000000, 1'b0, 2'b00, 8'h00, "R5 overflow");
        issue(24'h0, 24'h0, 56'h7F_FFFFFF_FFFFFF, 1'b0, 2'b00, 8'h00, "R5 round overflow");
        issue(24'h000100, 24'h000100, 56'h00_010000_000000, 1'b0, 2'b00, 8'hC1, "R5 sticky L keeps C S");
        issue(24'h0, 24'h0, 56'h00_000000_000000, 1'b0, 2'b00, 8'h3E, "R4 zero result");
        issue(24'h400000, 24'hC00000, 56'h0, 1'b0, 2'b01, 8'h00, "R6 down flags");
        issue(24'h100000, 24'h100000, 56'h0, 1'b0, 2'b10, 8'h00, "R6 up flags");

        // R8 start while busy is dropped
        model(24'h222222, 24'h333333, 56'h00_050000_000000, 1'b0, 2'b00, 8'h00, er, ec);
        e.acc = er; e.ccr = ec; e.req = "R8 busy start";
        sb.push_back(e);
        @(negedge clk);
        op_a_i = 24'h222222; op_b_i = 24'h333333; acc_i = 56'h00_050000_000000;
        sub_i = 1'b0; scale_i = 2'b00; ccr_i = 8'h00;
        start_i = 1'b1;
        @(negedge clk);
        op_a_i = 24'h7FFFFF; op_b_i = 24'h800000; acc_i = 56'h12_345678_9ABCDE;
        sub_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (!done_o) @(negedge clk);
        repeat (8) @(negedge clk);
        check("R8 queue drained", 64'(sb.size()), 64'h0);

        for (int n = 0; n < 300; n++) begin
            logic [55:0] ra;
            ra = {$urandom, $urandom};
            if (n % 3 != 0) ra[55:47] = {9{ra[46]}};
            issue(24'($urandom), 24'($urandom), ra, 1'($urandom), 2'($urandom),
                  8'($urandom), "R6 random");
        end
        repeat (4) @(negedge clk);
        check("R7 all results seen", 64'(sb.size()), 64'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule